// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps the time of day as a 64-bit count of nanoseconds for a precision-time hardware clock. On every cycle of its reference clock it adds a 32-bit addend into a 32-bit phase accumulator. Each time that accumulator carries out, the time count grows by a programmable nanosecond step. The average rate of the clock is therefore set by the addend. Software trims the clock frequency by rewriting one register; the clock input itself is never changed. A bypass mode drops the accumulator and adds the step on every enabled cycle.

Software reaches the block over a simple 32-bit register bus. Through it, software can read the time coherently as two words and load a new 64-bit time atomically. It can also retune the rate, seed or inspect the accumulator, and return the whole block to its reset state from the control register. The clock-source field is stored and read back for the surrounding clock-selection logic. It has no effect on counting inside this block.

Top module: `tod_clock`

## Requirements
- R1: After reset, the registers read as follows. Control (offset 0x00) reads 0x000A0000, which is a step of 10 ns, stopped, no bypass and clock source 0. The addend (0x20) reads 0x999999A4. The accumulator (0x24), the time low word (0x1C) and the time high word (0x18) all read 0.
- R2: While the run bit (control bit 2) is clear, neither the accumulator nor the time count changes.
- R3: While running without bypass, each cycle adds the addend into the accumulator modulo 2^32. The time count grows by the step field (control bits 25:16, in ns) exactly on the cycles where that addition carries out of bit 31.
- R4: While running with bypass (control bit 3) set, the time count grows by the step on every cycle and the accumulator holds its value.
- R5: A read of the low word returns time bits 31:0 and captures time bits 63:32. Every later read of the high word returns that captured value until the next low-word read, even if the time has moved on.
- R6: A write to the low word does not change the time. A later write to the high word loads the time with {high data, last low data} in one step.
- R7: Writing control with bit 5 set returns every register, the staged low word and the captured high word to their reset values on that edge. Bit 5 always reads 0.
- R8: Rewriting the addend changes the counting rate from the next cycle, with the accumulator value kept.
- R9: The accumulator can be written and read at 0x24. A written value is the starting phase for the next addition.
- R10: The step and clock-source (control bits 1:0) fields read back as written. A new step takes effect on the next carry.
- R11: A high-word load on a cycle where the count would also advance takes priority. That increment is lost and counting resumes from the loaded value.
- R12: A step that overflows bit 31 of the count carries into bit 32, so the 64-bit time is one continuous count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one accumulation step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access; 0 for unmapped offsets |

## Verification
The rate path is run with the default addend, a quarter-scale addend and an all-ones addend, each for a different number of cycles. Together these separate an off-by-one in the carry detection, a wrong modulo in the accumulator and a step taken from the wrong field. A run that starts from a written accumulator phase shows whether a written phase is kept or ignored. A bypass run across the 2^32 ns boundary exposes a missing low-to-high carry. A high read taken after the time has moved shows whether the high word comes from the capture or from the live count. Loading while counting with bypass shows whether the load or the increment wins.

// File: rtl/tod_pkg.sv
// Shared constants and types for the nanosecond time counter.
// Assumes a 32-bit register bus with byte offsets and a 64-bit time split in two words.
package tod_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;
    localparam int TIME_W = 64;
    localparam int ACC_W  = 32;
    localparam int STEP_W = 10;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_TIME_HI = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_TIME_LO = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_ADDEND  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_PHASE   = 8'h24;

    // Control bit positions
    localparam int CB_SRC_LSB  = 0;
    localparam int CB_RUN      = 2;
    localparam int CB_BYPASS   = 3;
    localparam int CB_SRST     = 5;
    localparam int CB_STEP_LSB = 16;

    localparam logic [STEP_W-1:0] DEF_STEP   = 10'd10;
    localparam logic [ACC_W-1:0]  DEF_ADDEND = 32'h9999_99A4;

    typedef struct packed {
        logic [STEP_W-1:0] step;
        logic              bypass;
        logic              run;
        logic [1:0]        src;
    } tod_ctrl_t;

    localparam tod_ctrl_t CTRL_RST = '{step: DEF_STEP, bypass: 1'b0, run: 1'b0, src: 2'b00};
endpackage

// File: rtl/tod_regbus.sv
// Register decode for the time counter: control, addend, staged low word,
// captured high word and read multiplexer. Assumes single-cycle accesses;
// read data is combinational from registered state.
module tod_regbus
    import tod_pkg::*;
#(
    parameter int P_BUS_W  = BUS_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_TIME_W = TIME_W,
    parameter int P_ACC_W  = ACC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [P_ADDR_W-1:0] bus_addr,
    input  logic [P_BUS_W-1:0]  bus_wdata,
    output logic [P_BUS_W-1:0]  bus_rdata,
    input  logic [P_TIME_W-1:0] time_now,
    input  logic [P_ACC_W-1:0]  phase_now,
    output tod_ctrl_t           ctrl,
    output logic [P_ACC_W-1:0]  addend,
    output logic                phase_wr,
    output logic [P_ACC_W-1:0]  phase_wdata,
    output logic                load,
    output logic [P_TIME_W-1:0] load_value,
    output logic                soft_clr
);
    localparam int HALF = P_TIME_W / 2;

    logic            wr_ctrl, wr_lo, wr_hi, wr_add, rd_lo;
    logic [HALF-1:0] stage_lo;
    logic [HALF-1:0] snap_hi;
    tod_ctrl_t       ctrl_new;

    // Access strobes
    always_comb begin
        wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
        wr_lo   = bus_sel && bus_wr && (bus_addr == OFS_TIME_LO);
        wr_hi   = bus_sel && bus_wr && (bus_addr == OFS_TIME_HI);
        wr_add  = bus_sel && bus_wr && (bus_addr == OFS_ADDEND);
        rd_lo   = bus_sel && !bus_wr && (bus_addr == OFS_TIME_LO);
    end

    // Control field unpacking from write data
    always_comb begin
        ctrl_new.step   = bus_wdata[CB_STEP_LSB +: STEP_W];
        ctrl_new.bypass = bus_wdata[CB_BYPASS];
        ctrl_new.run    = bus_wdata[CB_RUN];
        ctrl_new.src    = bus_wdata[CB_SRC_LSB +: 2];
    end

    assign soft_clr    = wr_ctrl && bus_wdata[CB_SRST];
    assign phase_wr    = bus_sel && bus_wr && (bus_addr == OFS_PHASE) && !soft_clr;
    assign phase_wdata = bus_wdata[P_ACC_W-1:0];
    assign load        = wr_hi;
    assign load_value  = {bus_wdata[HALF-1:0], stage_lo};

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) ctrl <= CTRL_RST;
        else if (wr_ctrl)       ctrl <= ctrl_new;
    end

    // Addend register
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) addend <= DEF_ADDEND;
        else if (wr_add)        addend <= bus_wdata[P_ACC_W-1:0];
    end

    // Staged low word for the atomic 64-bit load
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) stage_lo <= '0;
        else if (wr_lo)         stage_lo <= bus_wdata[HALF-1:0];
    end

    // High-word capture on each low-word read
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) snap_hi <= '0;
        else if (rd_lo)         snap_hi <= time_now[P_TIME_W-1:HALF];
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                OFS_CTRL: begin
                    bus_rdata[CB_STEP_LSB +: STEP_W] = ctrl.step;
                    bus_rdata[CB_BYPASS]             = ctrl.bypass;
                    bus_rdata[CB_RUN]                = ctrl.run;
                    bus_rdata[CB_SRC_LSB +: 2]       = ctrl.src;
                end
                OFS_TIME_LO: bus_rdata[HALF-1:0]    = time_now[HALF-1:0];
                OFS_TIME_HI: bus_rdata[HALF-1:0]    = snap_hi;
                OFS_ADDEND:  bus_rdata[P_ACC_W-1:0] = addend;
                OFS_PHASE:   bus_rdata[P_ACC_W-1:0] = phase_now;
                default:     bus_rdata = '0;
            endcase
        end
    end

    // R7
    srst_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (ctrl == CTRL_RST && addend == DEF_ADDEND));

    // R5
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && !soft_clr) |=> $stable(snap_hi));
endmodule

// File: rtl/tod_accum.sv
// Fractional phase accumulator: adds the addend every running cycle and
// reports the carry out. Assumes bypass freezes the phase.
module tod_accum #(
    parameter int P_ACC_W = tod_pkg::ACC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic               bypass,
    input  logic [P_ACC_W-1:0] addend,
    input  logic               phase_wr,
    input  logic [P_ACC_W-1:0] phase_wdata,
    output logic [P_ACC_W-1:0] phase,
    output logic               carry
);
    logic [P_ACC_W:0] sum;
    logic             active;

    // Wide sum and carry detect
    always_comb begin
        active = run && !bypass;
        sum    = {1'b0, phase} + {1'b0, addend};
        carry  = active && sum[P_ACC_W];
    end

    // Phase register update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) phase <= '0;
        else if (phase_wr) phase <= phase_wdata;
        else if (active)   phase <= sum[P_ACC_W-1:0];
    end

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass && !phase_wr && !clr) |=>
            phase == P_ACC_W'($past(phase) + $past(addend)));

    // R2
    phase_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !phase_wr && !clr) |=> $stable(phase));

    // R4
    phase_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bypass && !phase_wr && !clr) |=> $stable(phase));
endmodule

// File: rtl/tod_counter.sv
// 64-bit nanosecond time register: loads atomically, otherwise advances by
// the step on an accumulator carry or on every cycle in bypass.
module tod_counter #(
    parameter int P_TIME_W = tod_pkg::TIME_W,
    parameter int P_STEP_W = tod_pkg::STEP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                run,
    input  logic                bypass,
    input  logic                carry,
    input  logic [P_STEP_W-1:0] step,
    input  logic                load,
    input  logic [P_TIME_W-1:0] load_value,
    output logic [P_TIME_W-1:0] count
);
    logic                advance;
    logic [P_TIME_W-1:0] step_ext;

    // Advance decision and step widening
    always_comb begin
        advance  = run && (bypass || carry);
        step_ext = {{(P_TIME_W-P_STEP_W){1'b0}}, step};
    end

    // Time register update; load wins over advance
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (load)     count <= load_value;
        else if (advance)  count <= count + step_ext;
    end

    // R6
    load_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> count == $past(load_value));

    // R2
    count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load && !clr) |=> $stable(count));

    // R4
    count_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && bypass && !load && !clr) |=>
            count == $past(count) + P_TIME_W'($past(step)));
endmodule

// File: rtl/tod_clock.sv
// Top of the drift-compensated nanosecond time counter. Ties the register
// decode to the phase accumulator and the time register. Assumes clk is the
// already selected reference clock.
module tod_clock
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata
);
    tod_ctrl_t         ctrl;
    logic [ACC_W-1:0]  addend, phase, phase_wdata;
    logic              phase_wr, load, soft_clr, carry;
    logic [TIME_W-1:0] load_value, count;

    tod_regbus #(.P_BUS_W(BUS_W), .P_ADDR_W(ADDR_W), .P_TIME_W(TIME_W), .P_ACC_W(ACC_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .time_now(count), .phase_now(phase),
        .ctrl(ctrl), .addend(addend),
        .phase_wr(phase_wr), .phase_wdata(phase_wdata),
        .load(load), .load_value(load_value), .soft_clr(soft_clr)
    );

    tod_accum #(.P_ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .run(ctrl.run), .bypass(ctrl.bypass), .addend(addend),
        .phase_wr(phase_wr), .phase_wdata(phase_wdata),
        .phase(phase), .carry(carry)
    );

    tod_counter #(.P_TIME_W(TIME_W), .P_STEP_W(STEP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .run(ctrl.run), .bypass(ctrl.bypass), .carry(carry),
        .step(ctrl.step), .load(load), .load_value(load_value),
        .count(count)
    );

    // R3
    carry_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (ctrl.run && !ctrl.bypass));
endmodule

// File: tb/sim_tod_clock.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor pops
// and compares at the falling edge of each read cycle.
module sim_tod_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    // Bench model of the block's state
    logic [63:0] m_time  = 0;
    logic [31:0] m_phase = 0;
    logic [31:0] m_add   = 32'h9999_99A4;
    logic [9:0]  m_step  = 10'd10;

    localparam logic [7:0] A_CTRL = 8'h00, A_HI = 8'h18, A_LO = 8'h1C,
                           A_ADD = 8'h20, A_PH = 8'h24;

    tod_clock u0 (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
                  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    always #5 clk = ~clk;

    // Monitor: compare each read with the next queued expectation
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL unexpected read: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 0;
    endtask

    task automatic idle(input int k);
        repeat (k) @(posedge clk);
        #1;
    endtask

    // Run n counting cycles with the given control word (run bit added here)
    task automatic run_n(input int n, input logic [31:0] c);
        wr(A_CTRL, c | 32'h4);
        idle(n - 1);
        wr(A_CTRL, c & ~32'h4);
        m_step = c[25:16];
        for (int i = 0; i < n; i++) begin
            if (c[3]) m_time = m_time + 64'(m_step);
            else begin
                logic [32:0] s;
                s = {1'b0, m_phase} + {1'b0, m_add};
                m_phase = s[31:0];
                if (s[32]) m_time = m_time + 64'(m_step);
            end
        end
    endtask

    task automatic check_time(input string t);
        rd(A_LO, m_time[31:0], t);
        rd(A_HI, m_time[63:32], t);
        rd(A_PH, m_phase, t);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset values
        rd(A_CTRL, 32'h000A_0000, "R1 ctrl");
        rd(A_ADD, 32'h9999_99A4, "R1 addend");
        rd(A_PH, 0, "R1 phase");
        rd(A_LO, 0, "R1 lo");
        rd(A_HI, 0, "R1 hi");
        // R2 stopped: nothing moves
        idle(20);
        check_time("R2 stopped");
        // R3 default addend, 100 cycles
        run_n(100, 32'h000A_0000);
        check_time("R3 default addend");
        // R8 retune the addend, phase carried over
        wr(A_ADD, 32'h4000_0000); m_add = 32'h4000_0000;
        run_n(37, 32'h000A_0000);
        check_time("R8 quarter addend");
        // R10 new step and source field
        wr(A_ADD, 32'hFFFF_FFFF); m_add = 32'hFFFF_FFFF;
        run_n(50, 32'h0007_0002);
        rd(A_CTRL, 32'h0007_0002, "R10 ctrl readback");
        check_time("R10 step 7 all-ones addend");
        // R9 written phase seeds the next carry
        wr(A_PH, 32'hFFFF_FFF0); m_phase = 32'hFFFF_FFF0;
        rd(A_PH, 32'hFFFF_FFF0, "R9 phase readback");
        wr(A_ADD, 32'h20); m_add = 32'h20;
        run_n(1, 32'h0007_0000);
        check_time("R9 seeded carry");
        // R6 staged low write then atomic load
        wr(A_LO, 32'h89AB_CDEF);
        check_time("R6 low write staged only");
        wr(A_HI, 32'h0123_4567); m_time = 64'h0123_4567_89AB_CDEF;
        check_time("R6 atomic load");
        // R12 and R4: bypass across the 32-bit boundary; R5 snapshot
        wr(A_LO, 32'hFFFF_FFF0);
        wr(A_HI, 32'h5); m_time = 64'h5_FFFF_FFF0;
        rd(A_LO, 32'hFFFF_FFF0, "R5 lo before move");
        run_n(2, 32'h000A_0008);
        rd(A_HI, 32'h5, "R5 hi from capture");
        check_time("R12 R4 bypass carry into high word");
        // R11 load wins over increment while running in bypass
        wr(A_CTRL, 32'h000A_000C);
        wr(A_LO, 32'h100);
        wr(A_HI, 32'h2);
        wr(A_CTRL, 32'h000A_0008);
        m_time = 64'h2_0000_010A;
        check_time("R11 load priority");
        // R7 soft reset
        wr(A_ADD, 32'h1234_5678);
        wr(A_CTRL, 32'h0003_0027);
        rd(A_CTRL, 32'h000A_0000, "R7 ctrl");
        rd(A_ADD, 32'h9999_99A4, "R7 addend");
        m_time = 0; m_phase = 0;
        check_time("R7 time and phase");
        idle(5);
        check_time("R7 stays stopped");
        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule